// File: doc/BRIEF.md
# Single-Precision Floating-Point Compare

This block compares two single-precision IEEE-754 operands, the first operand (A) against the second (B). It produces a 2-bit condition code and an invalid-operation flag. The condition code is also placed into a status word. A start strobe launches one compare. One clock later a done strobe marks the cycle in which the code and the flag are valid. Both results then hold until the next start.

Two variants are selected per compare. The quiet compare treats quiet NaNs as an ordinary unordered outcome. The signalling compare treats any unordered outcome as an invalid operation. Ordering of numbers uses sign-magnitude rules: the two signed zeros compare equal, infinities order normally, and subnormals order by magnitude.

Top module: `fp_cmp_cc`

## Requirements
- R1: The condition code is 0 when A equals B, 1 when A is less than B, 2 when A is greater than B, and 3 when the pair is unordered. A pair is unordered when either operand is a NaN.
- R2: An operand is a NaN when its exponent field (bits 30:23) is all ones and its fraction (bits 22:0) is nonzero. An infinity (all-ones exponent, zero fraction) is an ordinary ordered value, and two equal infinities compare equal.
- R3: +0 (0x00000000) and -0 (0x80000000) compare equal, whichever operand holds which.
- R4: Non-NaN operands order by sign-magnitude. A negative operand is less than a positive one. Two positive operands order by magnitude. Two negative operands order opposite to their magnitudes.
- R5: With `sig_mode`=0 (quiet), `invalid_o` is 1 only when an operand is a signalling NaN, that is a NaN whose fraction bit 22 is 0. A quiet NaN (bit 22 set) gives code 3 with `invalid_o`=0.
- R6: With `sig_mode`=1 (signalling), `invalid_o` is 1 exactly when the code is 3.
- R7: `done_o` is 1 in the single cycle that follows a cycle with `start`=1, and 0 otherwise. `cc_o` and `invalid_o` carry that compare's result in the same cycle.
- R8: `status_o` bits 11:10 always equal `cc_o`, and all its other bits are 0. There is one condition-code field only.
- R9: Without `start`, changes on the operand and mode inputs leave `cc_o`, `invalid_o` and `status_o` unchanged.
- R10: While reset (`rst_n`=0) is asserted, `done_o`, `cc_o`, `invalid_o` and `status_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches one compare with the current inputs |
| sig_mode | input | 1 | 1 selects the signalling compare, 0 the quiet compare |
| opa | input | 32 | First operand (A), single precision |
| opb | input | 32 | Second operand (B), single precision |
| cc_o | output | 2 | Condition code of the last compare |
| invalid_o | output | 1 | Invalid-operation flag of the last compare |
| done_o | output | 1 | One-cycle strobe, result valid |
| status_o | output | 32 | Status word, condition code at bits 11:10 |

## Verification
The bench targets these cases:
- **Signed zeros.** A bitwise equality test would wrongly report +0 and -0 as ordered.
- **Negative pairs.** Forgetting to invert the order would swap codes 1 and 2.
- **Infinities against NaNs.** A NaN test that ignores the fraction would mark infinities unordered.
- **NaN kind against variant.** A mixed-up bit 22 or variant select would flag quiet NaNs in the quiet compare, or miss them in the signalling one.
- **Idle-cycle stimulus.** Input changes without `start` catch outputs that follow the inputs combinationally instead of holding.

// File: rtl/fp_cmp_pkg.sv
package fp_cmp_pkg;
  localparam int FW = 32;
  localparam int EW = 8;
  localparam int MW = 23;

  typedef enum logic [1:0] {
    CC_EQ  = 2'd0,
    CC_LT  = 2'd1,
    CC_GT  = 2'd2,
    CC_UNO = 2'd3
  } cc_e;

  // Ordering of two non-NaN values by sign and magnitude.
  function automatic cc_e order_num(input logic [FW-1:0] a, input logic [FW-1:0] b);
    logic [FW-2:0] ma, mb;
    logic sa, sb;
    ma = a[FW-2:0];
    mb = b[FW-2:0];
    sa = a[FW-1];
    sb = b[FW-1];
    if (ma == '0 && mb == '0) return CC_EQ;
    if (a == b) return CC_EQ;
    if (sa != sb) return sa ? CC_LT : CC_GT;
    if (!sa) return (ma < mb) ? CC_LT : CC_GT;
    return (ma < mb) ? CC_GT : CC_LT;
  endfunction
endpackage

// File: rtl/fp_cmp_class.sv
module fp_cmp_class #(
  parameter int FW = 32,
  parameter int EW = 8,
  parameter int MW = 23
) (
  input  logic [FW-1:0] val,
  output logic          is_nan,
  output logic          is_snan,
  output logic          is_zero
);
  localparam int QB = MW - 1;
  logic [EW-1:0] ex;
  logic [MW-1:0] fr;
  assign ex = val[FW-2 -: EW];
  assign fr = val[MW-1:0];
  always_comb begin
    is_nan  = (&ex) && (fr != '0);
    is_snan = is_nan && !fr[QB];
    is_zero = (val[FW-2:0] == '0);
  end
endmodule

// File: rtl/fp_cmp_order.sv
module fp_cmp_order
  import fp_cmp_pkg::*;
(
  input  logic [FW-1:0] a,
  input  logic [FW-1:0] b,
  input  logic          nan_a,
  input  logic          nan_b,
  output logic [1:0]    cc,
  output logic          unord
);
  always_comb begin
    unord = nan_a | nan_b;
    cc    = unord ? CC_UNO : order_num(a, b);
  end
endmodule

// File: rtl/fp_cmp_cc.sv
module fp_cmp_cc
  import fp_cmp_pkg::*;
#(
  parameter int STAT_W = 32,
  parameter int CC_LSB = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sig_mode,
  input  logic [FW-1:0]     opa,
  input  logic [FW-1:0]     opb,
  output logic [1:0]        cc_o,
  output logic              invalid_o,
  output logic              done_o,
  output logic [STAT_W-1:0] status_o
);
  logic [1:0] nan_w, snan_w, zero_w;
  logic [FW-1:0] ops [2];
  assign ops[0] = opa;
  assign ops[1] = opb;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fp_cmp_class #(.FW(FW), .EW(EW), .MW(MW)) u_cls (
      .val(ops[g]), .is_nan(nan_w[g]), .is_snan(snan_w[g]), .is_zero(zero_w[g])
    );
  end

  logic [1:0] cc_w;
  logic unord_w, snan_any_w, inv_w;

  fp_cmp_order u_ord (
    .a(opa), .b(opb), .nan_a(nan_w[0]), .nan_b(nan_w[1]),
    .cc(cc_w), .unord(unord_w)
  );

  assign snan_any_w = |snan_w;
  assign inv_w      = sig_mode ? unord_w : snan_any_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cc_o      <= CC_EQ;
      invalid_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= start;
      if (start) begin
        cc_o      <= cc_w;
        invalid_o <= inv_w;
      end
    end
  end

  always_comb begin
    status_o = '0;
    status_o[CC_LSB +: 2] = cc_o;
  end

  // R7
  done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done_o);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done_o);
  // R6
  sig_unord_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && sig_mode && unord_w) |=> (invalid_o && cc_o == CC_UNO));
  // R5
  quiet_no_snan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sig_mode && !snan_any_w) |=> !invalid_o);
  // R3
  zeros_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (&zero_w)) |=> (cc_o == CC_EQ));
  // R9
  hold_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(cc_o) && $stable(invalid_o)));
  // R8
  status_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[CC_LSB +: 2] == cc_o) && ($countones(status_o) == $countones(cc_o)));
endmodule

// File: tb/test_fp_cmp_cc.sv
`timescale 1ns/1ps
module test_fp_cmp_cc;
  logic clk = 0, rst_n = 0, start = 0, sig_mode = 0;
  logic [31:0] opa = 0, opb = 0;
  logic [1:0] cc_o;
  logic invalid_o, done_o;
  logic [31:0] status_o;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  fp_cmp_cc i_fp_cmp_cc (
    .clk(clk), .rst_n(rst_n), .start(start), .sig_mode(sig_mode),
    .opa(opa), .opb(opb), .cc_o(cc_o), .invalid_o(invalid_o),
    .done_o(done_o), .status_o(status_o)
  );

  // {a, b, mode, cc, inv}
  localparam int NV = 18;
  localparam logic [67:0] VEC [NV] = '{
    {32'h3F800000, 32'h40000000, 1'b0, 2'd1, 1'b0}, // R1 1<2
    {32'h40000000, 32'h3F800000, 1'b0, 2'd2, 1'b0}, // R1 2>1
    {32'h40600000, 32'h40600000, 1'b0, 2'd0, 1'b0}, // R1 eq
    {32'hBF800000, 32'hC0000000, 1'b0, 2'd2, 1'b0}, // R4 -1>-2
    {32'hC0000000, 32'hBF800000, 1'b0, 2'd1, 1'b0}, // R4 -2<-1
    {32'hBF800000, 32'h3F800000, 1'b1, 2'd1, 1'b0}, // R4 neg<pos
    {32'h00000000, 32'h80000000, 1'b0, 2'd0, 1'b0}, // R3
    {32'h80000000, 32'h00000000, 1'b1, 2'd0, 1'b0}, // R3
    {32'h00000001, 32'h00000002, 1'b0, 2'd1, 1'b0}, // R4 subnormal
    {32'h7F800000, 32'h7F7FFFFF, 1'b0, 2'd2, 1'b0}, // R2 inf>max
    {32'hFF800000, 32'h7F800000, 1'b1, 2'd1, 1'b0}, // R2 -inf<inf
    {32'h7F800000, 32'h7F800000, 1'b1, 2'd0, 1'b0}, // R2 inf==inf
    {32'h7FC00000, 32'h3F800000, 1'b0, 2'd3, 1'b0}, // R5 qNaN quiet
    {32'h3F800000, 32'hFFC00000, 1'b1, 2'd3, 1'b1}, // R6 qNaN signalling
    {32'h7F800001, 32'h3F800000, 1'b0, 2'd3, 1'b1}, // R5 sNaN a quiet
    {32'h00000000, 32'h7FA00000, 1'b0, 2'd3, 1'b1}, // R5 sNaN b quiet
    {32'h7F800001, 32'h7FC00000, 1'b1, 2'd3, 1'b1}, // R6 sNaN signalling
    {32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0, 2'd3, 1'b0}  // R2 same qNaN unordered
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [31:0] a, input logic [31:0] b, input logic m);
    opa = a; opb = b; sig_mode = m; start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 done", {31'b0, done_o}, 0);
    chk("R10 cc", {30'b0, cc_o}, 0);
    chk("R10 inv", {31'b0, invalid_o}, 0);
    chk("R10 status", status_o, 0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      launch(VEC[i][67:36], VEC[i][35:4], VEC[i][3]);
      chk("R7 done", {31'b0, done_o}, 1);
      chk("R1 cc", {30'b0, cc_o}, {30'b0, VEC[i][2:1]});
      chk("R5/R6 inv", {31'b0, invalid_o}, {31'b0, VEC[i][0]});
      chk("R8 status", status_o, {20'b0, VEC[i][2:1], 10'b0});
    end
    // R7: done drops after one cycle
    @(negedge clk);
    chk("R7 done low", {31'b0, done_o}, 0);
    // R9: idle input changes ignored (last result: cc 3, inv 0)
    opa = 32'h3F800000; opb = 32'h40000000; sig_mode = 1;
    repeat (3) @(negedge clk);
    chk("R9 cc hold", {30'b0, cc_o}, 3);
    chk("R9 inv hold", {31'b0, invalid_o}, 0);
    chk("R9 status hold", status_o, 32'h00000C00);
    chk("R9 done low", {31'b0, done_o}, 0);
    // R6: signalling compare of ordered values gives no flag
    launch(32'h40000000, 32'h40000000, 1'b1);
    chk("R6 ordered no inv", {31'b0, invalid_o}, 0);
    chk("R1 eq", {30'b0, cc_o}, 0);
    // R10: reset clears held result
    launch(32'h7F800001, 32'h0, 1'b1);
    rst_n = 0;
    @(negedge clk);
    chk("R10 cc after", {30'b0, cc_o}, 0);
    chk("R10 inv after", {31'b0, invalid_o}, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule